// File: doc/BRIEF.md
# Local Interrupt Vector Dispatcher

This block sits beside one processor core and decides what happens when one of its local interrupt sources fires. There are three sources: a timer expiry, and two external interrupt pins, called LINT0 and LINT1 here. Each source owns one entry in a small vector table. When an event arrives, the block looks up that source's entry and does one of three things. It drops the event. It pulses one of three request lines to the core: system-management, non-maskable, or external-interrupt. Or it posts a fixed interrupt, carrying a vector and a trigger mode, to the pending-interrupt logic, which is outside this block.

The block also decides whether a request from a legacy interrupt controller is taken. A request is taken when the core's global enable is off, or when the LINT0 entry is unmasked. A taken request is handled exactly like a LINT0 pin event. In a multi-core system the same controller line is wired to every core's dispatcher, and each dispatcher makes its own choice.

The reset contents of the LINT0 entry depend on the core-ID input, so that only core 0 boots with the legacy path open. The fixed-post outputs are a valid strobe with no ready. The pending-interrupt logic must take every strobe in the cycle it appears, so there is no back-pressure.

Top module: `lvd_top`

## Requirements
- R1: Under synchronous reset (rst_n low at a clock edge), every entry loads 0x10000, with the mask bit set. The one exception is core 0 (core_id == 0): its LINT0 entry loads 0x00700, which is external-interrupt mode with the mask clear. All request outputs are low after reset.
- R2: Entry bit 16 is the mask. An event from a source whose entry has this bit set produces no output.
- R3: Entry bits 10:8 select the delivery mode: 000 fixed, 010 system-management, 100 non-maskable, 111 external-interrupt. Every other code is reserved and produces no output.
- R4: An unmasked event in system-management, non-maskable or external-interrupt mode pulses smi_req, nmi_req or intr_req high. The pulse lasts exactly one cycle, in the cycle after the event.
- R5: An unmasked fixed-mode event raises fix_valid for one cycle, in the cycle after the event. In that cycle fix_vector equals entry bits 7:0.
- R6: fix_level equals entry bit 15 for the two pin sources. It is always 0 when the timer is the source.
- R7: Timer events use the same mode decoding as pin events. For example, a timer entry in non-maskable mode raises nmi_req.
- R8: legacy_accept is high whenever glb_en is low or the LINT0 mask bit is clear. Otherwise it is low.
- R9: Only a rising edge of legacy_req counts. When legacy_accept is high on that edge, it is dispatched as a LINT0 event. A level held high, a falling edge, or a refused edge produces no output.
- R10: A table write takes effect for events from the next cycle on. An event in the same cycle as the write uses the old entry.
- R11: When several sources fire in the same cycle, their request lines are ORed together. Only one fixed post is made per cycle, with priority timer, then LINT0, then LINT1. The other fixed events are dropped.
- R12: reg_rdata shows the entry selected by reg_sel: 0 for the timer, 1 for LINT0, 2 for LINT1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_id | input | CORE_ID_W | Identity of this core; sampled during reset |
| glb_en | input | 1 | Global enable of the local controller |
| reg_we | input | 1 | Table write strobe |
| reg_sel | input | SEL_W | Entry select for write and read |
| reg_wdata | input | 17 | Write data |
| reg_rdata | output | 17 | Selected entry contents |
| tmr_evt | input | 1 | Timer expiry pulse |
| pin_evt | input | NUM_PINS | Pin event pulses; bit 0 is LINT0 |
| legacy_req | input | 1 | Legacy interrupt-controller request level |
| legacy_accept | output | 1 | Legacy request would be taken |
| smi_req | output | 1 | System-management request pulse |
| nmi_req | output | 1 | Non-maskable request pulse |
| intr_req | output | 1 | External-interrupt request pulse |
| fix_valid | output | 1 | Fixed interrupt post strobe |
| fix_vector | output | 8 | Posted vector |
| fix_level | output | 1 | Posted trigger mode, 1 for level |

## Verification
The bench builds the block with its default parameters: two pins, a 4-bit core ID, and therefore a 2-bit select. At this size every entry, every mode code, and the full three-way fixed-post priority can be reached. The bench resets the block with core_id 0 and again with core_id 5, which reaches both reset images of LINT0. It drives the legacy line both with and without global enable, so that acceptance and refusal are both seen.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int VEC_W     = 8;
  localparam int ENTRY_W   = 17;
  localparam int MASK_BIT  = 16;
  localparam int LEVEL_BIT = 15;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_EXTINT = 3'b111
  } dmode_e;

  localparam logic [ENTRY_W-1:0] ENTRY_RST  = 17'h10000;
  localparam logic [ENTRY_W-1:0] LINT0_BOOT = 17'h00700;
endpackage

// File: rtl/lvd_vtable.sv
module lvd_vtable
  import lvd_pkg::*;
#(
  parameter int NUM_SRC    = 3,
  parameter int SEL_W      = 2,
  parameter int CORE_ID_W  = 4,
  parameter int LEGACY_SRC = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CORE_ID_W-1:0]            core_id,
  input  logic                            we,
  input  logic [SEL_W-1:0]                sel,
  input  logic [ENTRY_W-1:0]              wdata,
  output logic [ENTRY_W-1:0]              rdata,
  output logic [NUM_SRC-1:0][ENTRY_W-1:0] entries
);
  logic boot_core;
  assign boot_core = (core_id == '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_entry
    logic [ENTRY_W-1:0] rst_val;
    if (s == LEGACY_SRC) begin : g_boot
      assign rst_val = boot_core ? LINT0_BOOT : ENTRY_RST;
    end else begin : g_plain
      assign rst_val = ENTRY_RST;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[s] <= rst_val;
      end else if (we && sel == SEL_W'(s)) begin
        entries[s] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (sel == SEL_W'(s)) rdata = entries[s];
    end
  end
endmodule

// File: rtl/lvd_legacy.sv
module lvd_legacy (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic glb_en,
  input  logic lint0_masked,
  output logic rise,
  output logic accept,
  output logic take
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign rise   = req & ~req_q;
  assign accept = ~glb_en | ~lint0_masked;
  assign take   = rise & accept;
endmodule

// File: rtl/lvd_route.sv
module lvd_route
  import lvd_pkg::*;
#(
  parameter int NUM_SRC   = 3,
  parameter int TIMER_SRC = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              evt,
  input  logic [NUM_SRC-1:0][ENTRY_W-1:0] entries,
  output logic                            smi_req,
  output logic                            nmi_req,
  output logic                            intr_req,
  output logic                            fix_valid,
  output logic [VEC_W-1:0]                fix_vector,
  output logic                            fix_level
);
  logic             smi_d, nmi_d, intr_d, fix_d, lvl_d;
  logic [VEC_W-1:0] vec_d;
  logic             unused_bits;

  always_comb begin
    smi_d  = 1'b0;
    nmi_d  = 1'b0;
    intr_d = 1'b0;
    fix_d  = 1'b0;
    lvl_d  = 1'b0;
    vec_d  = '0;
    unused_bits = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      unused_bits = unused_bits ^ (^entries[s][LEVEL_BIT-1:MODE_LSB+MODE_W]);
      if (evt[s] && !entries[s][MASK_BIT]) begin
        case (entries[s][MODE_LSB +: MODE_W])
          DM_SMI:    smi_d  = 1'b1;
          DM_NMI:    nmi_d  = 1'b1;
          DM_EXTINT: intr_d = 1'b1;
          DM_FIXED: begin
            if (!fix_d) begin
              fix_d = 1'b1;
              vec_d = entries[s][VEC_W-1:0];
              lvl_d = (s != TIMER_SRC) && entries[s][LEVEL_BIT];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_req    <= 1'b0;
      nmi_req    <= 1'b0;
      intr_req   <= 1'b0;
      fix_valid  <= 1'b0;
      fix_vector <= '0;
      fix_level  <= 1'b0;
    end else begin
      smi_req    <= smi_d;
      nmi_req    <= nmi_d;
      intr_req   <= intr_d;
      fix_valid  <= fix_d;
      fix_vector <= vec_d;
      fix_level  <= lvl_d;
    end
  end
endmodule

// File: rtl/lvd_top.sv
module lvd_top
  import lvd_pkg::*;
#(
  parameter int NUM_PINS  = 2,
  parameter int CORE_ID_W = 4,
  parameter int NUM_SRC   = NUM_PINS + 1,
  parameter int SEL_W     = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CORE_ID_W-1:0] core_id,
  input  logic                 glb_en,
  input  logic                 reg_we,
  input  logic [SEL_W-1:0]     reg_sel,
  input  logic [16:0]          reg_wdata,
  output logic [16:0]          reg_rdata,
  input  logic                 tmr_evt,
  input  logic [NUM_PINS-1:0]  pin_evt,
  input  logic                 legacy_req,
  output logic                 legacy_accept,
  output logic                 smi_req,
  output logic                 nmi_req,
  output logic                 intr_req,
  output logic                 fix_valid,
  output logic [7:0]           fix_vector,
  output logic                 fix_level
);
  localparam int TIMER_SRC = 0;
  localparam int LINT0_SRC = 1;

  logic [NUM_SRC-1:0][ENTRY_W-1:0] entries;
  logic [NUM_SRC-1:0]              evt_all;
  logic                            legacy_rise;
  logic                            legacy_take;

  lvd_vtable #(
    .NUM_SRC    (NUM_SRC),
    .SEL_W      (SEL_W),
    .CORE_ID_W  (CORE_ID_W),
    .LEGACY_SRC (LINT0_SRC)
  ) u_vtable (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_id (core_id),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .entries (entries)
  );

  lvd_legacy u_legacy (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (legacy_req),
    .glb_en       (glb_en),
    .lint0_masked (entries[LINT0_SRC][MASK_BIT]),
    .rise         (legacy_rise),
    .accept       (legacy_accept),
    .take         (legacy_take)
  );

  always_comb begin
    evt_all            = '0;
    evt_all[TIMER_SRC] = tmr_evt;
    for (int p = 0; p < NUM_PINS; p++) begin
      evt_all[p + 1] = pin_evt[p];
    end
    evt_all[LINT0_SRC] = pin_evt[0] | legacy_take;
  end

  lvd_route #(
    .NUM_SRC   (NUM_SRC),
    .TIMER_SRC (TIMER_SRC)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_all),
    .entries    (entries),
    .smi_req    (smi_req),
    .nmi_req    (nmi_req),
    .intr_req   (intr_req),
    .fix_valid  (fix_valid),
    .fix_vector (fix_vector),
    .fix_level  (fix_level)
  );
endmodule

// File: rtl/lvd_checker.sv
module lvd_checker
  import lvd_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            glb_en,
  input logic [NUM_SRC-1:0]              evt_all,
  input logic [NUM_SRC-1:0][ENTRY_W-1:0] entries,
  input logic                            legacy_rise,
  input logic                            legacy_accept,
  input logic                            smi_req,
  input logic                            nmi_req,
  input logic                            intr_req,
  input logic                            fix_valid,
  input logic                            fix_level
);
  logic [NUM_SRC-1:0] live;
  logic               any_out;
  logic               unused_entry;

  always_comb begin
    unused_entry = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      live[s] = evt_all[s] & ~entries[s][MASK_BIT];
      unused_entry = unused_entry ^ (^entries[s][MASK_BIT-1:0]);
    end
  end

  assign any_out = smi_req | nmi_req | intr_req | fix_valid;

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> !any_out); // R2

  AST_TIMER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all == NUM_SRC'(1)) |=> !fix_level); // R6

  AST_POST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fix_valid) |-> $past(|evt_all)); // R5

  AST_ACCEPT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> legacy_accept); // R8

  AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_rise && !legacy_accept && evt_all == '0) |=> !any_out); // R9
endmodule

bind lvd_top lvd_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .glb_en        (glb_en),
  .evt_all       (evt_all),
  .entries       (entries),
  .legacy_rise   (legacy_rise),
  .legacy_accept (legacy_accept),
  .smi_req       (smi_req),
  .nmi_req       (nmi_req),
  .intr_req      (intr_req),
  .fix_valid     (fix_valid),
  .fix_level     (fix_level)
);

// File: tb/lvd_top_tb.sv
module lvd_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  core_id = '0;
  logic        glb_en = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [16:0] reg_wdata = '0;
  logic [16:0] reg_rdata;
  logic        tmr_evt = 1'b0;
  logic [1:0]  pin_evt = '0;
  logic        legacy_req = 1'b0;
  logic        legacy_accept;
  logic        smi_req, nmi_req, intr_req, fix_valid, fix_level;
  logic [7:0]  fix_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvd_top u_dut (
    .clk(clk), .rst_n(rst_n), .core_id(core_id), .glb_en(glb_en),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_evt(tmr_evt), .pin_evt(pin_evt), .legacy_req(legacy_req),
    .legacy_accept(legacy_accept), .smi_req(smi_req), .nmi_req(nmi_req),
    .intr_req(intr_req), .fix_valid(fix_valid), .fix_vector(fix_vector),
    .fix_level(fix_level)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // outputs packed as {smi,nmi,intr,valid,level,vector}
  function automatic logic [31:0] outs();
    return {19'd0, smi_req, nmi_req, intr_req, fix_valid, fix_level, fix_vector};
  endfunction

  function automatic logic [31:0] pack(bit s, bit n, bit i, bit v, bit l, logic [7:0] vec);
    return {19'd0, s, n, i, v, l, vec};
  endfunction

  task automatic do_reset(logic [3:0] id);
    @(negedge clk);
    rst_n = 1'b0; core_id = id;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] sel, logic [16:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] sel, logic [16:0] exp);
    reg_sel = sel;
    #1;
    check(tag, {15'd0, reg_rdata}, {15'd0, exp});
  endtask

  // pulse events for one cycle, then check outputs in the following cycle
  task automatic fire(string tag, bit t, logic [1:0] p, logic [31:0] exp);
    @(negedge clk);
    tmr_evt = t; pin_evt = p;
    @(negedge clk);
    tmr_evt = 1'b0; pin_evt = '0;
    check(tag, outs(), exp);
  endtask

  task automatic t_reset();
    do_reset(4'd0);
    rd("R1 R12 timer entry core0", 2'd0, 17'h10000);
    rd("R1 R12 LINT0 entry core0", 2'd1, 17'h00700);
    rd("R1 R12 LINT1 entry core0", 2'd2, 17'h10000);
    check("R1 outputs after reset", outs(), 32'd0);
    do_reset(4'd5);
    rd("R1 LINT0 entry core5", 2'd1, 17'h10000);
  endtask

  task automatic t_masked();
    do_reset(4'd5);
    fire("R2 all masked", 1'b1, 2'b11, 32'd0);
  endtask

  task automatic t_modes();
    do_reset(4'd5);
    wr(2'd2, 17'h00200);
    fire("R4 smi pulse", 1'b0, 2'b10, pack(1,0,0,0,0,8'h00));
    @(negedge clk);
    check("R4 smi one cycle", outs(), 32'd0);
    wr(2'd2, 17'h00400);
    fire("R4 nmi pulse", 1'b0, 2'b10, pack(0,1,0,0,0,8'h00));
    wr(2'd2, 17'h00700);
    fire("R4 extint pulse", 1'b0, 2'b10, pack(0,0,1,0,0,8'h00));
    wr(2'd2, 17'h00100);
    fire("R3 reserved 001", 1'b0, 2'b10, 32'd0);
    wr(2'd2, 17'h00300);
    fire("R3 reserved 011", 1'b0, 2'b10, 32'd0);
  endtask

  task automatic t_fixed();
    do_reset(4'd5);
    wr(2'd1, 17'h08045);
    fire("R5 R6 LINT0 level", 1'b0, 2'b01, pack(0,0,0,1,1,8'h45));
    @(negedge clk);
    check("R5 post one cycle", outs(), 32'd0);
    wr(2'd1, 17'h00046);
    fire("R6 LINT0 edge", 1'b0, 2'b01, pack(0,0,0,1,0,8'h46));
    wr(2'd0, 17'h08077);
    fire("R6 timer always edge", 1'b1, 2'b00, pack(0,0,0,1,0,8'h77));
    wr(2'd0, 17'h00400);
    fire("R7 timer nmi mode", 1'b1, 2'b00, pack(0,1,0,0,0,8'h00));
  endtask

  task automatic t_legacy();
    do_reset(4'd0);
    glb_en = 1'b1;
    #1;
    check("R8 accept lint0 unmasked", {31'd0, legacy_accept}, 32'd1);
    @(negedge clk);
    legacy_req = 1'b1;
    @(negedge clk);
    check("R9 legacy rise to extint", outs(), pack(0,0,1,0,0,8'h00));
    @(negedge clk);
    check("R9 held level ignored", outs(), 32'd0);
    legacy_req = 1'b0;
    @(negedge clk);
    check("R9 falling edge ignored", outs(), 32'd0);
    wr(2'd1, 17'h10700);
    #1;
    check("R8 refuse when masked and enabled", {31'd0, legacy_accept}, 32'd0);
    @(negedge clk);
    legacy_req = 1'b1;
    @(negedge clk);
    check("R9 refused rise silent", outs(), 32'd0);
    legacy_req = 1'b0;
    glb_en = 1'b0;
    #1;
    check("R8 accept when disabled", {31'd0, legacy_accept}, 32'd1);
    glb_en = 1'b1;
  endtask

  task automatic t_write_timing();
    do_reset(4'd5);
    wr(2'd0, 17'h00033);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 17'h00400; tmr_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tmr_evt = 1'b0;
    check("R10 same-cycle write uses old", outs(), pack(0,0,0,1,0,8'h33));
    fire("R10 new entry next cycle", 1'b1, 2'b00, pack(0,1,0,0,0,8'h00));
  endtask

  task automatic t_simul();
    do_reset(4'd5);
    wr(2'd0, 17'h00011);
    wr(2'd1, 17'h08022);
    wr(2'd2, 17'h00200);
    fire("R11 timer wins post, smi ored", 1'b1, 2'b11, pack(1,0,0,1,0,8'h11));
    wr(2'd0, 17'h10011);
    fire("R11 LINT0 next in priority", 1'b1, 2'b11, pack(1,0,0,1,1,8'h22));
    wr(2'd2, 17'h00055);
    fire("R11 LINT0 over LINT1", 1'b0, 2'b11, pack(0,0,0,1,1,8'h22));
  endtask

  initial begin
    t_reset();
    t_masked();
    t_modes();
    t_fixed();
    t_legacy();
    t_write_timing();
    t_simul();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule